// File: doc/BRIEF.md
# Cache Transaction Queue Allocator

This block sits between the core and the cache lookup pipe. The core offers load and store requests on a valid/ready channel. Each request carries a write flag, a 20-bit byte address, a 32-bit store word and an 8-bit request ID. Each accepted request is placed in a free slot of an eight-entry pool. A small state machine in that slot then follows the request through its life. The request waits for a lookup and goes through the pipe. It may wait for a dirty line to be written back, and it may wait for a far-memory fill. It then waits to be answered, and the slot is freed when the core takes the answer.

Lookups are issued to the pipe oldest first. Far-memory line reads are named by the 3-bit slot index, so up to eight misses can be outstanding, and fills may come back in any order. Answers to the core carry the core's own request ID, so requests can complete out of order.

Every outgoing stream (lookup issue, far-memory read, core response) is valid/ready. While valid is high and ready is low, the sender keeps valid high and does not withdraw the transfer. The core must hold all of its request fields steady while `req_valid` is high and `req_ready` is low. Pipe results, write-back completions and fills are one-cycle pulses with no back-pressure.

Top module: `tq_alloc`

## Requirements
- R1: After reset all eight slots are free. `req_ready` is 1, and `lu_valid`, `fm_rd_valid` and `rsp_valid` are 0.
- R2: A request is taken only on a cycle with `req_valid` and `req_ready` both high, and at most one is taken per cycle. Each request takes its own slot, and the free slot with the lowest index is chosen.
- R3: `req_ready` is low exactly when all eight slots are occupied. A core that sees `req_valid` high with `req_ready` low keeps its write flag, address, data and ID steady.
- R4: When a response handshake frees a slot in a full pool, `req_ready` is high in the next cycle.
- R5: `lu_valid` is high while any slot waits for lookup. `lu_idx` names the waiting slot that was allocated earliest, and `lu_write`, `lu_addr` and `lu_wdata` carry that slot's request. While `lu_ready` is low the same slot stays offered.
- R6: A pipe result (`res_valid` pulse with `res_idx`) to an issued slot is decoded from `res_kind`. 0 is a hit and goes to response. 1 is a clean miss and goes to fill wait. 2 is a dirty miss: the slot waits for a `wb_done_valid` pulse naming it, then goes to fill wait. Code 3 has no effect.
- R7: A slot in fill wait that has not yet asked far memory raises `fm_rd_valid`. The lowest such index is offered, with `fm_rd_idx` equal to the slot index and `fm_rd_line` equal to address bits [19:4]. Each slot asks exactly once.
- R8: A `fill_valid` pulse naming a slot whose far-memory read was accepted moves that slot to response. Fills may arrive in any order, so responses can leave in an order different from acceptance.
- R9: `rsp_valid` is high while any slot is answered and not yet taken. The lowest such index is shown on `rsp_idx`, with that request's `rsp_id` and `rsp_write`. The slot is freed on the `rsp_ready` handshake.
- R10: A result, write-back completion or fill that names a slot not in the matching state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request offered |
| req_ready | output | 1 | A slot is free |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 32 | Store word |
| req_id | input | 8 | Core request ID |
| lu_valid | output | 1 | Lookup issue offered |
| lu_ready | input | 1 | Pipe takes the lookup |
| lu_idx | output | 3 | Slot being issued |
| lu_write | output | 1 | Store flag of issued slot |
| lu_addr | output | 20 | Address of issued slot |
| lu_wdata | output | 32 | Store word of issued slot |
| res_valid | input | 1 | Pipe result pulse |
| res_idx | input | 3 | Slot the result is for |
| res_kind | input | 2 | 0 hit, 1 clean miss, 2 dirty miss, 3 no effect |
| wb_done_valid | input | 1 | Dirty write-back finished |
| wb_done_idx | input | 3 | Slot the write-back belonged to |
| fm_rd_valid | output | 1 | Far-memory line read offered |
| fm_rd_ready | input | 1 | Far memory takes the read |
| fm_rd_idx | output | 3 | Tag of the read (slot index) |
| fm_rd_line | output | 16 | Line address (address bits 19:4) |
| fill_valid | input | 1 | Fill returned |
| fill_idx | input | 3 | Slot tag of the fill |
| rsp_valid | output | 1 | Core response offered |
| rsp_ready | input | 1 | Core takes the response |
| rsp_idx | output | 3 | Slot being answered |
| rsp_id | output | 8 | Core request ID of the answer |
| rsp_write | output | 1 | Store flag of the answer |

## Verification
The checker takes for granted that the core obeys the hold rule. Once `req_valid` is high with `req_ready` low, valid stays high and the request fields do not move. The bench keeps to this by re-driving an unaccepted request unchanged until its handshake completes. The stub pipe and far-memory model mostly send results, write-back completions and fills only to slots in the matching state. A few deliberately stray pulses and reserved result codes are mixed in, and the bench's reference model expects them to change nothing.

// File: rtl/tq_pkg.sv
package tq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_LOOKUP    = 3'd1,
    ST_WAIT_FILL = 3'd2,
    ST_WB_PEND   = 3'd3,
    ST_DONE      = 3'd4
  } tq_state_e;

  localparam logic [1:0] RES_HIT        = 2'd0;
  localparam logic [1:0] RES_MISS       = 2'd1;
  localparam logic [1:0] RES_MISS_DIRTY = 2'd2;

endpackage

// File: rtl/tq_lowest_pick.sv
module tq_lowest_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tq_age_track.sv
// Keeps, per occupied slot, the number of occupied slots allocated after it.
// Ranks stay distinct and below N, so the largest rank marks the oldest.
module tq_age_track #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  occ,
  input  logic          alloc_en,
  input  logic [IW-1:0] alloc_idx,
  input  logic          free_en,
  input  logic [IW-1:0] free_idx,
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [IW-1:0] oldest_idx
);
  logic [IW-1:0] rank     [N];
  logic [IW-1:0] rank_nxt [N];
  logic [IW-1:0] best;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (alloc_en && alloc_idx == IW'(i)) begin
        rank_nxt[i] = '0;
      end else if (!occ[i] || (free_en && free_idx == IW'(i))) begin
        rank_nxt[i] = '0;
      end else begin
        rank_nxt[i] = rank[i] + IW'(alloc_en)
                    - IW'(free_en && (rank[i] > rank[free_idx]));
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) rank[i] <= '0;
      else        rank[i] <= rank_nxt[i];
    end
  end

  always_comb begin
    any        = 1'b0;
    best       = '0;
    oldest_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!any || rank[i] > best)) begin
        any        = 1'b1;
        best       = rank[i];
        oldest_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tq_entry.sv
module tq_entry #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int ID_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_en,
  input  logic                alloc_write,
  input  logic [ADDR_W-1:0]   alloc_addr,
  input  logic [DATA_W-1:0]   alloc_wdata,
  input  logic [ID_W-1:0]     alloc_id,
  input  logic                issue_en,
  input  logic                res_en,
  input  logic [1:0]          res_kind,
  input  logic                wb_done_en,
  input  logic                fm_sent_en,
  input  logic                fill_en,
  input  logic                rsp_en,
  output tq_pkg::tq_state_e   state,
  output logic                issued,
  output logic                fm_sent,
  output logic                write,
  output logic [ADDR_W-1:0]   addr,
  output logic [DATA_W-1:0]   wdata,
  output logic [ID_W-1:0]     id
);
  import tq_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      issued  <= 1'b0;
      fm_sent <= 1'b0;
      write   <= 1'b0;
      addr    <= '0;
      wdata   <= '0;
      id      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (alloc_en) begin
            state   <= ST_LOOKUP;
            issued  <= 1'b0;
            fm_sent <= 1'b0;
            write   <= alloc_write;
            addr    <= alloc_addr;
            wdata   <= alloc_wdata;
            id      <= alloc_id;
          end
        end
        ST_LOOKUP: begin
          if (!issued) begin
            if (issue_en) issued <= 1'b1;
          end else if (res_en) begin
            case (res_kind)
              RES_HIT:        state <= ST_DONE;
              RES_MISS: begin
                state   <= ST_WAIT_FILL;
                fm_sent <= 1'b0;
              end
              RES_MISS_DIRTY: state <= ST_WB_PEND;
              default:        state <= ST_LOOKUP;
            endcase
          end
        end
        ST_WB_PEND: begin
          if (wb_done_en) begin
            state   <= ST_WAIT_FILL;
            fm_sent <= 1'b0;
          end
        end
        ST_WAIT_FILL: begin
          if (!fm_sent) begin
            if (fm_sent_en) fm_sent <= 1'b1;
          end else if (fill_en) begin
            state <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (rsp_en) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tq_alloc.sv
module tq_alloc #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 32,
  parameter int ID_W        = 8,
  parameter int OFF_W       = 4,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int LINE_W     = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ID_W-1:0]   req_id,
  output logic              lu_valid,
  input  logic              lu_ready,
  output logic [IDX_W-1:0]  lu_idx,
  output logic              lu_write,
  output logic [ADDR_W-1:0] lu_addr,
  output logic [DATA_W-1:0] lu_wdata,
  input  logic              res_valid,
  input  logic [IDX_W-1:0]  res_idx,
  input  logic [1:0]        res_kind,
  input  logic              wb_done_valid,
  input  logic [IDX_W-1:0]  wb_done_idx,
  output logic              fm_rd_valid,
  input  logic              fm_rd_ready,
  output logic [IDX_W-1:0]  fm_rd_idx,
  output logic [LINE_W-1:0] fm_rd_line,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_idx,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [ID_W-1:0]   rsp_id,
  output logic              rsp_write
);
  import tq_pkg::*;

  tq_state_e          e_state  [NUM_ENTRIES];
  logic               e_issued [NUM_ENTRIES];
  logic               e_sent   [NUM_ENTRIES];
  logic               e_write  [NUM_ENTRIES];
  logic [ADDR_W-1:0]  e_addr   [NUM_ENTRIES];
  logic [DATA_W-1:0]  e_wdata  [NUM_ENTRIES];
  logic [ID_W-1:0]    e_id     [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] idle_v, occ_v, cand_v, fmwait_v, done_v;
  logic [IDX_W-1:0]       alloc_idx;
  logic                   req_fire, lu_fire, fm_fire, rsp_fire;
  logic [ADDR_W-1:0]      fm_addr;

  // Slot status vectors
  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      idle_v[i]   = (e_state[i] == ST_IDLE);
      occ_v[i]    = !idle_v[i];
      cand_v[i]   = (e_state[i] == ST_LOOKUP) && !e_issued[i];
      fmwait_v[i] = (e_state[i] == ST_WAIT_FILL) && !e_sent[i];
      done_v[i]   = (e_state[i] == ST_DONE);
    end
  end

  tq_lowest_pick #(.N(NUM_ENTRIES), .IW(IDX_W)) free_pick_i (
    .req(idle_v), .any(req_ready), .idx(alloc_idx)
  );

  tq_lowest_pick #(.N(NUM_ENTRIES), .IW(IDX_W)) fm_pick_i (
    .req(fmwait_v), .any(fm_rd_valid), .idx(fm_rd_idx)
  );

  tq_lowest_pick #(.N(NUM_ENTRIES), .IW(IDX_W)) rsp_pick_i (
    .req(done_v), .any(rsp_valid), .idx(rsp_idx)
  );

  assign req_fire = req_valid && req_ready;
  assign lu_fire  = lu_valid && lu_ready;
  assign fm_fire  = fm_rd_valid && fm_rd_ready;
  assign rsp_fire = rsp_valid && rsp_ready;

  tq_age_track #(.N(NUM_ENTRIES), .IW(IDX_W)) age_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .occ        (occ_v),
    .alloc_en   (req_fire),
    .alloc_idx  (alloc_idx),
    .free_en    (rsp_fire),
    .free_idx   (rsp_idx),
    .cand       (cand_v),
    .any        (lu_valid),
    .oldest_idx (lu_idx)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    tq_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) entry_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_en    (req_fire && alloc_idx == IDX_W'(g)),
      .alloc_write (req_write),
      .alloc_addr  (req_addr),
      .alloc_wdata (req_wdata),
      .alloc_id    (req_id),
      .issue_en    (lu_fire && lu_idx == IDX_W'(g)),
      .res_en      (res_valid && res_idx == IDX_W'(g)),
      .res_kind    (res_kind),
      .wb_done_en  (wb_done_valid && wb_done_idx == IDX_W'(g)),
      .fm_sent_en  (fm_fire && fm_rd_idx == IDX_W'(g)),
      .fill_en     (fill_valid && fill_idx == IDX_W'(g)),
      .rsp_en      (rsp_fire && rsp_idx == IDX_W'(g)),
      .state       (e_state[g]),
      .issued      (e_issued[g]),
      .fm_sent     (e_sent[g]),
      .write       (e_write[g]),
      .addr        (e_addr[g]),
      .wdata       (e_wdata[g]),
      .id          (e_id[g])
    );
  end

  // Payload steering
  assign lu_write   = e_write[lu_idx];
  assign lu_addr    = e_addr[lu_idx];
  assign lu_wdata   = e_wdata[lu_idx];
  assign fm_addr    = e_addr[fm_rd_idx];
  assign fm_rd_line = fm_addr[ADDR_W-1:OFF_W];
  assign rsp_id     = e_id[rsp_idx];
  assign rsp_write  = e_write[rsp_idx];

endmodule

// File: rtl/tq_alloc_chk.sv
module tq_alloc_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int ID_W   = 8,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [ID_W-1:0]   req_id,
  input logic              lu_valid,
  input logic              lu_ready,
  input logic [IDX_W-1:0]  lu_idx,
  input logic              fm_rd_valid,
  input logic              fm_rd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_wdata)
                                && $stable(req_id) && $stable(req_write)); // R3

  AST_READY_DROP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid)); // R2

  AST_READY_AFTER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && rsp_valid && rsp_ready |=> req_ready); // R4

  AST_LU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lu_valid && !lu_ready |=> lu_valid && lu_idx == $past(lu_idx)); // R5

  AST_FM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fm_rd_valid && !fm_rd_ready |=> fm_rd_valid); // R7

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid); // R9
endmodule

bind tq_alloc tq_alloc_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .req_id(req_id),
  .lu_valid(lu_valid), .lu_ready(lu_ready), .lu_idx(lu_idx),
  .fm_rd_valid(fm_rd_valid), .fm_rd_ready(fm_rd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready)
);

// File: tb/tq_alloc_tb_top.sv
module tq_alloc_tb_top;
  localparam int N = 8;
  localparam int S_IDLE = 0, S_LU = 1, S_WF = 2, S_WB = 3, S_DONE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [19:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [7:0]  req_id = 0;
  logic        req_ready;
  logic        lu_valid, lu_write;
  logic        lu_ready = 0;
  logic [2:0]  lu_idx;
  logic [19:0] lu_addr;
  logic [31:0] lu_wdata;
  logic        res_valid = 0;
  logic [2:0]  res_idx = 0;
  logic [1:0]  res_kind = 0;
  logic        wb_done_valid = 0;
  logic [2:0]  wb_done_idx = 0;
  logic        fm_rd_valid;
  logic        fm_rd_ready = 0;
  logic [2:0]  fm_rd_idx;
  logic [15:0] fm_rd_line;
  logic        fill_valid = 0;
  logic [2:0]  fill_idx = 0;
  logic        rsp_valid, rsp_write;
  logic        rsp_ready = 0;
  logic [2:0]  rsp_idx;
  logic [7:0]  rsp_id;

  tq_alloc dut_i (.*);

  int n_checks = 0, n_errors = 0;

  // Reference model: per-slot bookkeeping plus a FIFO of slots waiting for lookup
  int          m_st   [N];
  bit          m_iss  [N];
  bit          m_sent [N];
  bit          m_wr   [N];
  logic [19:0] m_addr [N];
  logic [31:0] m_wd   [N];
  logic [7:0]  m_id   [N];
  int          m_seq  [N];
  int          lookup_q[$];
  int          seq_ctr = 0, last_rsp_seq = -1, n_rsp = 0;
  bit          req_fire_last = 0, ooo_seen = 0, full_seen = 0;

  function automatic int first_in(int st, bit need_unsent);
    for (int i = 0; i < N; i++)
      if (m_st[i] == st && (!need_unsent || !m_sent[i])) return i;
    return -1;
  endfunction

  int a_i, f_i, r_i, l_i;
  bit res_ok, wb_ok, fill_ok;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_st[i] = S_IDLE; m_iss[i] = 0; m_sent[i] = 0;
      end
      lookup_q.delete();
      req_fire_last = 0;
    end else begin
      a_i = first_in(S_IDLE, 0);
      f_i = first_in(S_WF, 1);
      r_i = first_in(S_DONE, 0);
      l_i = (lookup_q.size() > 0) ? lookup_q[0] : -1;
      res_ok  = res_valid && m_st[res_idx] == S_LU && m_iss[res_idx];
      wb_ok   = wb_done_valid && m_st[wb_done_idx] == S_WB;
      fill_ok = fill_valid && m_st[fill_idx] == S_WF && m_sent[fill_idx];
      req_fire_last = req_valid && a_i >= 0;
      if (l_i >= 0 && lu_ready) begin
        m_iss[l_i] = 1;
        void'(lookup_q.pop_front());
      end
      if (res_ok) begin
        case (res_kind)
          2'd0: m_st[res_idx] = S_DONE;
          2'd1: begin m_st[res_idx] = S_WF; m_sent[res_idx] = 0; end
          2'd2: m_st[res_idx] = S_WB;
          default: ;
        endcase
      end
      if (wb_ok) begin m_st[wb_done_idx] = S_WF; m_sent[wb_done_idx] = 0; end
      if (fill_ok) m_st[fill_idx] = S_DONE;
      if (f_i >= 0 && fm_rd_ready) m_sent[f_i] = 1;
      if (r_i >= 0 && rsp_ready) begin
        m_st[r_i] = S_IDLE;
        n_rsp++;
        if (m_seq[r_i] < last_rsp_seq) ooo_seen = 1;
        if (m_seq[r_i] > last_rsp_seq) last_rsp_seq = m_seq[r_i];
      end
      if (req_fire_last) begin
        m_st[a_i] = S_LU; m_iss[a_i] = 0; m_sent[a_i] = 0;
        m_wr[a_i] = req_write; m_addr[a_i] = req_addr;
        m_wd[a_i] = req_wdata; m_id[a_i] = req_id;
        m_seq[a_i] = seq_ctr++;
        lookup_q.push_back(a_i);
      end
    end
  end

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int e_a, e_f, e_r;
    e_a = first_in(S_IDLE, 0);
    e_f = first_in(S_WF, 1);
    e_r = first_in(S_DONE, 0);
    if (e_a < 0) full_seen = 1;
    check(req_ready == (e_a >= 0), "R3/R4", "req_ready", req_ready, e_a >= 0);
    check(lu_valid == (lookup_q.size() > 0), "R5", "lu_valid", lu_valid, lookup_q.size() > 0);
    if (lu_valid && lookup_q.size() > 0) begin
      check(lu_idx == lookup_q[0], "R2/R5", "lu_idx", lu_idx, lookup_q[0]);
      check(lu_addr == m_addr[lookup_q[0]] && lu_wdata == m_wd[lookup_q[0]]
            && lu_write == m_wr[lookup_q[0]], "R5", "lu payload", lu_addr, m_addr[lookup_q[0]]);
    end
    check(fm_rd_valid == (e_f >= 0), "R6/R7", "fm_rd_valid", fm_rd_valid, e_f >= 0);
    if (fm_rd_valid && e_f >= 0) begin
      check(fm_rd_idx == e_f, "R7", "fm_rd_idx", fm_rd_idx, e_f);
      check(fm_rd_line == m_addr[e_f][19:4], "R7", "fm_rd_line", fm_rd_line, m_addr[e_f][19:4]);
    end
    check(rsp_valid == (e_r >= 0), "R8/R9/R10", "rsp_valid", rsp_valid, e_r >= 0);
    if (rsp_valid && e_r >= 0) begin
      check(rsp_idx == e_r, "R9", "rsp_idx", rsp_idx, e_r);
      check(rsp_id == m_id[e_r] && rsp_write == m_wr[e_r], "R9", "rsp_id", rsp_id, m_id[e_r]);
    end
  endtask

  function automatic int pick_slot(int st, int need_sent);
    int c[$];
    for (int i = 0; i < N; i++)
      if (m_st[i] == st && (need_sent < 0 || (st == S_LU ? m_iss[i] : m_sent[i]) == need_sent[0]))
        c.push_back(i);
    if (c.size() == 0) return -1;
    return c[$urandom % c.size()];
  endfunction

  task automatic drive(int p_req, int p_lu, int p_fm, int p_rsp);
    int s, k;
    if (!(req_valid && !req_fire_last)) begin
      req_valid = ($urandom % 100) < p_req;
      req_write = $urandom % 2;
      req_addr  = 20'($urandom);
      req_wdata = $urandom;
      req_id    = req_id + 8'd1;
    end
    lu_ready    = ($urandom % 100) < p_lu;
    fm_rd_ready = ($urandom % 100) < p_fm;
    rsp_ready   = ($urandom % 100) < p_rsp;
    // pipe results, normally legal, now and then stray (R10) or reserved code (R6)
    s = pick_slot(S_LU, 1);
    res_valid = 0;
    if (($urandom % 100) < 5) begin
      res_valid = 1; res_idx = 3'($urandom); res_kind = 2'($urandom);
    end else if (s >= 0 && ($urandom % 100) < 50) begin
      k = $urandom % 10;
      res_valid = 1; res_idx = 3'(s);
      res_kind = (k < 4) ? 2'd0 : (k < 7) ? 2'd1 : (k < 9) ? 2'd2 : 2'd3;
    end
    s = pick_slot(S_WB, -1);
    wb_done_valid = 0;
    if (s >= 0 && ($urandom % 100) < 30) begin wb_done_valid = 1; wb_done_idx = 3'(s); end
    else if (($urandom % 100) < 3) begin wb_done_valid = 1; wb_done_idx = 3'($urandom); end
    s = pick_slot(S_WF, 1);
    fill_valid = 0;
    if (s >= 0 && ($urandom % 100) < 35) begin fill_valid = 1; fill_idx = 3'(s); end
    else if (($urandom % 100) < 5) begin fill_valid = 1; fill_idx = 3'($urandom); end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1", "req_ready at reset", req_ready, 1);
    check(!lu_valid && !fm_rd_valid && !rsp_valid, "R1", "valids at reset",
          {lu_valid, fm_rd_valid, rsp_valid}, 0);
    rst_n = 1'b1;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk); compare_all(); drive(85, 30, 40, 15);
    end
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk); compare_all(); drive(50, 60, 60, 60);
    end
    for (int c = 0; c < 1500; c++) begin
      @(negedge clk); compare_all(); drive(0, 90, 90, 90);
    end
    @(negedge clk); compare_all();
    check(full_seen, "R3", "pool filled at least once", full_seen, 1);
    check(ooo_seen, "R8", "out-of-order completion seen", ooo_seen, 1);
    check(n_rsp > 100, "R2/R9", "responses delivered", n_rsp, 100);
    check(req_ready && !lu_valid && !rsp_valid, "R9", "pool drained",
          {req_ready, lu_valid, rsp_valid}, 3'b100);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule